// File: doc/BRIEF.md
# Pipelined Heap Priority Queue

This block is a max-priority queue for values of width `W`. It is arranged as a complete binary tree of `L` levels, and each level has its own node storage and its own comparator. Every node keeps a value, an occupancy flag and a count of the free slots in its subtree. An accepted operation travels down the tree as a token, one level per clock. The token carries its kind, the node index it addresses at the next level, and for an insertion the value being pushed down.

An insertion enters at the root. At each node the larger of the token value and the stored value stays in the node, and the smaller one moves on. The token always goes towards a child that still has room, and the left child is taken when both have room. A removal hands out the root value at once. It then refills each emptied node from its larger occupied child, level by level. Because the levels work on different tokens at the same time, a new operation can start every second cycle, whatever the tree depth. The caller offers at most one request per cycle and watches `ready`, `full` and `empty`. A removed value comes back on `deq_data`, qualified by `deq_valid`.

Top module: `pheap_queue`

## Requirements
- R1: While reset is held and after it is released, `empty` is 1, `full` is 0, `ready` is 1 and `deq_valid` is 0.
- R2: A removal is accepted when `deq_req` is 1, `ready` is 1 and `empty` is 0. In the cycle after the accepting clock edge, `deq_valid` is 1 for one cycle and `deq_data` holds the largest value stored at that edge.
- R3: Equal values are kept as separate entries, and each copy is returned by its own removal.
- R4: `full` is 1 once 2^L-1 values are stored. An insertion requested while `full` is 1 is ignored and no value is lost or added.
- R5: A removal requested while `empty` is 1 is ignored: `deq_valid` stays 0 and the queue stays empty.
- R6: When `deq_req` and `enq_req` are both 1 in the same cycle, only the removal is performed and the insertion value is dropped.
- R7: In the cycle after any accepted operation `ready` is 0, and every request made in that cycle is ignored. A request is therefore accepted at most once every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_req | input | 1 | Request to insert `enq_data` |
| enq_data | input | W | Value to insert |
| deq_req | input | 1 | Request to remove the maximum |
| deq_valid | output | 1 | One-cycle flag: `deq_data` holds a removed value |
| deq_data | output | W | Value returned by the last removal |
| full | output | 1 | No free slot is left in the tree |
| empty | output | 1 | No value is stored |
| ready | output | 1 | A request is taken this cycle if its other conditions hold |

## Verification
The bench returns duplicates one by one. A design that merged equal values in a node would drop one copy and report empty too early. It fills the tree to capacity and then offers one more, larger-than-most value: a design that mis-steered a token past a full subtree, or accepted the extra value, would return that value during the drain or lose a stored one. It holds an insertion across the blocked cycle after acceptance, so a design that took requests back to back would return the value twice. It also presents simultaneous insert and remove requests, so a design with the opposite precedence would return the wrong maximum afterwards.

// File: rtl/pheap_pkg.sv
package pheap_pkg;

  typedef enum logic [1:0] {
    TK_IDLE = 2'd0,
    TK_ENQ  = 2'd1,
    TK_DEQ  = 2'd2
  } tok_op_e;

  // Number of nodes in the subtree rooted at a node of level lvl in a tree of levels levels.
  function automatic int slots_below(input int levels, input int lvl);
    return (1 << (levels - lvl)) - 1;
  endfunction

endpackage

// File: rtl/pheap_level.sv
module pheap_level
  import pheap_pkg::*;
#(
  parameter int W   = 8,
  parameter int L   = 4,
  parameter int LVL = 0,
  localparam int LEAVES = 1 << (L - 1),
  localparam int CW     = L,
  localparam int PW     = (L > 1) ? L - 1 : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  // token arriving at this level
  input  tok_op_e                    in_op,
  input  logic [PW-1:0]              in_pos,
  input  logic [W-1:0]               in_val,
  // view of the level below
  input  logic [LEAVES-1:0][W-1:0]   ch_val,
  input  logic [LEAVES-1:0]          ch_occ,
  input  logic [LEAVES-1:0][CW-1:0]  ch_cap,
  // token leaving towards the level below
  output tok_op_e                    out_op,
  output logic [PW-1:0]              out_pos,
  output logic [W-1:0]               out_val,
  // view of this level for the level above
  output logic [LEAVES-1:0][W-1:0]   nd_val,
  output logic [LEAVES-1:0]          nd_occ,
  output logic [LEAVES-1:0][CW-1:0]  nd_cap
);

  localparam int SZ   = 1 << LVL;
  localparam int CAP0 = slots_below(L, LVL);

  logic [LEAVES-1:0][W-1:0]  val_q;
  logic [LEAVES-1:0]         occ_q;
  logic [LEAVES-1:0][CW-1:0] cap_q;

  function automatic logic [W-1:0] keep_larger(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a >= b) ? a : b;
  endfunction

  function automatic logic [W-1:0] pass_smaller(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a >= b) ? b : a;
  endfunction

  // insertion steers right only when the left subtree has no room
  function automatic logic enq_goes_right(input logic [CW-1:0] left_cap);
    return left_cap == '0;
  endfunction

  // refill takes the larger occupied child, left on a tie
  function automatic logic deq_takes_right(input logic lo, input logic ro,
                                           input logic [W-1:0] lv, input logic [W-1:0] rv);
    if (lo && ro) return rv > lv;
    return ro;
  endfunction

  // named internal events
  logic [PW:0]   pos_dbl;
  logic [PW-1:0] ci_l, ci_r;
  logic          node_busy;
  logic          ev_enq_right;
  logic          ev_deq_right;
  logic          ev_deq_has_child;
  logic [W-1:0]  node_v;

  assign pos_dbl          = {in_pos, 1'b0};
  assign ci_l             = pos_dbl[PW-1:0];
  assign ci_r             = ci_l | PW'(1);
  assign node_busy        = occ_q[in_pos];
  assign node_v           = val_q[in_pos];
  assign ev_enq_right     = enq_goes_right(ch_cap[ci_l]);
  assign ev_deq_right     = deq_takes_right(ch_occ[ci_l], ch_occ[ci_r], ch_val[ci_l], ch_val[ci_r]);
  assign ev_deq_has_child = ch_occ[ci_l] | ch_occ[ci_r];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LEAVES; i++) begin
        val_q[i] <= '0;
        occ_q[i] <= 1'b0;
        cap_q[i] <= (i < SZ) ? CW'(CAP0) : '0;
      end
      out_op  <= TK_IDLE;
      out_pos <= '0;
      out_val <= '0;
    end else begin
      out_op <= TK_IDLE;
      case (in_op)
        TK_ENQ: begin
          cap_q[in_pos] <= cap_q[in_pos] - CW'(1);
          if (!node_busy) begin
            val_q[in_pos] <= in_val;
            occ_q[in_pos] <= 1'b1;
          end else begin
            val_q[in_pos] <= keep_larger(node_v, in_val);
            out_op        <= TK_ENQ;
            out_pos       <= ev_enq_right ? ci_r : ci_l;
            out_val       <= pass_smaller(node_v, in_val);
          end
        end
        TK_DEQ: begin
          cap_q[in_pos] <= cap_q[in_pos] + CW'(1);
          if (ev_deq_has_child) begin
            val_q[in_pos] <= ev_deq_right ? ch_val[ci_r] : ch_val[ci_l];
            out_op        <= TK_DEQ;
            out_pos       <= ev_deq_right ? ci_r : ci_l;
            out_val       <= '0;
          end else begin
            occ_q[in_pos] <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign nd_val = val_q;
  assign nd_occ = occ_q;
  assign nd_cap = cap_q;

endmodule

// File: rtl/pheap_queue.sv
module pheap_queue
  import pheap_pkg::*;
#(
  parameter int W = 8,
  parameter int L = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_req,
  input  logic [W-1:0] enq_data,
  input  logic         deq_req,
  output logic         deq_valid,
  output logic [W-1:0] deq_data,
  output logic         full,
  output logic         empty,
  output logic         ready
);

  localparam int LEAVES = 1 << (L - 1);
  localparam int CW     = L;
  localparam int PW     = (L > 1) ? L - 1 : 1;
  localparam int TOTAL  = slots_below(L, 0);

  // per-level views; entry L is the empty level below the leaves
  logic [LEAVES-1:0][W-1:0]  lv_val [L+1];
  logic [LEAVES-1:0]         lv_occ [L+1];
  logic [LEAVES-1:0][CW-1:0] lv_cap [L+1];

  // tokens; entry 0 is the accepted request, entry g+1 leaves level g
  tok_op_e       tok_op  [L+1];
  logic [PW-1:0] tok_pos [L+1];
  logic [W-1:0]  tok_val [L+1];

  logic          busy_q;
  logic          acc_enq;
  logic          acc_deq;
  logic [CW-1:0] root_cap;

  assign lv_val[L] = '0;
  assign lv_occ[L] = '0;
  assign lv_cap[L] = '0;

  assign root_cap = lv_cap[0][0];
  assign full     = (root_cap == '0);
  assign empty    = (root_cap == CW'(TOTAL));
  assign ready    = !busy_q;

  assign acc_deq = ready && deq_req && !empty;
  assign acc_enq = ready && enq_req && !deq_req && !full;

  assign tok_op[0]  = acc_deq ? TK_DEQ : (acc_enq ? TK_ENQ : TK_IDLE);
  assign tok_pos[0] = '0;
  assign tok_val[0] = enq_data;

  for (genvar g = 0; g < L; g++) begin : g_lvl
    pheap_level #(
      .W  (W),
      .L  (L),
      .LVL(g)
    ) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_op  (tok_op[g]),
      .in_pos (tok_pos[g]),
      .in_val (tok_val[g]),
      .ch_val (lv_val[g+1]),
      .ch_occ (lv_occ[g+1]),
      .ch_cap (lv_cap[g+1]),
      .out_op (tok_op[g+1]),
      .out_pos(tok_pos[g+1]),
      .out_val(tok_val[g+1]),
      .nd_val (lv_val[g]),
      .nd_occ (lv_occ[g]),
      .nd_cap (lv_cap[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      deq_valid <= 1'b0;
      deq_data  <= '0;
    end else begin
      busy_q    <= acc_enq || acc_deq;
      deq_valid <= acc_deq;
      if (acc_deq) deq_data <= lv_val[0][0];
    end
  end

endmodule

// File: rtl/pheap_queue_chk.sv
module pheap_queue_chk
  import pheap_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    full,
  input logic    empty,
  input logic    ready,
  input logic    deq_valid,
  input logic    acc_enq,
  input logic    acc_deq,
  input tok_op_e tok1_op,
  input tok_op_e leaf_op
);

  AST_DEQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> $past(acc_deq)); // R2

  AST_ENQ_MAKES_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_enq |=> !empty); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !acc_deq) |=> full); // R4

  AST_LEAF_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_op == TK_IDLE); // R4

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !acc_enq) |=> empty); // R5

  AST_TOKEN_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (tok1_op != TK_IDLE) |-> !ready); // R7

endmodule

bind pheap_queue pheap_queue_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .full     (full),
  .empty    (empty),
  .ready    (ready),
  .deq_valid(deq_valid),
  .acc_enq  (acc_enq),
  .acc_deq  (acc_deq),
  .tok1_op  (tok_op[1]),
  .leaf_op  (tok_op[L])
);

// File: tb/pheap_queue_test.sv
`timescale 1ns/1ps
module pheap_queue_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_req = 1'b0;
  logic [7:0] enq_data = '0;
  logic       deq_req = 1'b0;
  logic       deq_valid;
  logic [7:0] deq_data;
  logic       full, empty, ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pheap_queue #(.W(8), .L(4)) uut (
    .clk(clk), .rst_n(rst_n), .enq_req(enq_req), .enq_data(enq_data),
    .deq_req(deq_req), .deq_valid(deq_valid), .deq_data(deq_data),
    .full(full), .empty(empty), .ready(ready)
  );

  always #2.5 clk = ~clk;

  // op: 1 insert, 2 remove, 3 both
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] d;
    logic       ev;
    logic [7:0] ed;
    logic       ef;
    logic       ee;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd5, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd1, 8'd9, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd1, 8'd3, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd1, 8'd9, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd9, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd9, 1'b0, 1'b0},
    '{2'd1, 8'd7, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd7, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd5, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd3, 1'b0, 1'b1},
    '{2'd2, 8'd0, 1'b0, 8'd0, 1'b0, 1'b1},
    '{2'd1, 8'd1, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd1, 1'b0, 1'b1},
    '{2'd1, 8'd4, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd1, 8'd6, 1'b0, 8'd0, 1'b0, 1'b0},
    '{2'd3, 8'd8, 1'b1, 8'd6, 1'b0, 1'b0},
    '{2'd2, 8'd0, 1'b1, 8'd4, 1'b0, 1'b1}
  };

  int mq [16];
  int mcnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at one falling edge, release at the next; outputs are sampled there
  task automatic apply(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    enq_req  = op[0];
    deq_req  = op[1];
    enq_data = d;
    @(negedge clk);
    enq_req = 1'b0;
    deq_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 empty during reset", empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 ready", ready, 1);
    chk("R1 deq_valid", deq_valid, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VECS[i].op == 2'd3) tag = "R6";
      else if (i == 4 || i == 5) tag = "R3";
      else if (VECS[i].op == 2'd2 && !VECS[i].ev) tag = "R5";
      else tag = "R2";
      apply(VECS[i].op, VECS[i].d);
      chk({tag, " deq_valid"}, deq_valid, VECS[i].ev);
      if (VECS[i].ev) chk({tag, " deq_data"}, deq_data, VECS[i].ed);
      chk({tag, " full"}, full, VECS[i].ef);
      chk({tag, " empty"}, empty, VECS[i].ee);
    end

    // R4: fill to capacity, refuse one more, drain in descending order
    for (int i = 0; i < 15; i++) begin
      int v;
      v = (i * 37 + 11) % 256;
      apply(2'd1, v[7:0]);
      mq[mcnt] = v;
      mcnt++;
      chk("R4 full while filling", full, (i == 14) ? 1 : 0);
    end
    apply(2'd1, 8'd200);
    chk("R4 full after refused insert", full, 1);
    chk("R4 no deq_valid on insert", deq_valid, 0);
    for (int k = 0; k < 15; k++) begin
      int best;
      best = 0;
      for (int j = 1; j < mcnt; j++) if (mq[j] > mq[best]) best = j;
      apply(2'd2, 8'd0);
      chk("R4 drain deq_valid", deq_valid, 1);
      chk("R4 drain order", deq_data, mq[best]);
      mq[best] = mq[mcnt-1];
      mcnt--;
      chk("R4 full released", full, 0);
    end
    chk("R5 empty after drain", empty, 1);
    apply(2'd2, 8'd0);
    chk("R5 removal on empty ignored", deq_valid, 0);
    chk("R5 still empty", empty, 1);

    // R7: an insertion held over the blocked cycle is taken once
    @(negedge clk);
    enq_req  = 1'b1;
    enq_data = 8'd50;
    @(negedge clk);
    chk("R7 ready low after accept", ready, 0);
    @(negedge clk);
    enq_req = 1'b0;
    chk("R7 ready back", ready, 1);
    apply(2'd2, 8'd0);
    chk("R7 value returned", deq_data, 50);
    chk("R7 single copy stored", empty, 1);
    apply(2'd2, 8'd0);
    chk("R7 no second copy", deq_valid, 0);

    finish_run();
  end

endmodule